// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block drives one software-requested conversion on an external converter that is reached through a small byte-wide register port. A `start` pulse with a channel number starts the run. The sequencer then acts as bus master. It polls the converter's status until the converter is idle, and it brings the converter up with read-modify-write accesses in a fixed order. It selects the channel with 16-sample averaging and starts the conversion. It waits for the end-of-conversion pulse, reads the two result bytes and powers the converter down again.

Every exit ends with a write of zero to the main control register, whether the run succeeds or fails. A failure can come from a bus error, from a converter that stays busy, or from a conversion that never finishes. This shutdown write leaves the converter quiet for the next caller. Retry spacing and the conversion timeout are counted in pulses of a free-running `tick` input, so the same block works with any time base.

The caller sees `busy` while a run is in progress. The run ends with exactly one single-cycle `done` or `error` pulse, and on `done` the 16-bit raw `result` is valid.

Top module: `adc_conv_seq`

## Requirements
- R1: After reset, `busy`, `done`, `error`, `bus_re` and `bus_we` are all low.
- R2: `start` is taken only while idle; a `start` raised while a run is in progress has no effect, so the run keeps its original channel and ends with a single pulse.
- R3: A run first reads the status register at address 0x04. When bit 0 of that read is 1, the sequencer waits POLL_GAP ticks and reads again, with at most POLL_MAX status reads in total. If all POLL_MAX reads return 1, the run goes to the shutdown write and then to `error`.
- R4: Once the status bit reads 0, the sequencer reads the control register at address 0x00 and writes back that value with bit 0 (0x01) set.
- R5: Next it writes address 0x01 with the channel number OR 0x60.
- R6: It then reads address 0x00 and writes back the value with 0x40 set. For channels ISENSE_CH_A and ISENSE_CH_B, the same write also sets 0x80.
- R7: It then reads address 0x00 and writes back the value with 0x04 set, which starts the conversion.
- R8: After that start write, the sequencer waits for an `eoc` pulse. If EOC_TIMEOUT ticks pass with no pulse, it goes to the shutdown write and then to `error`.
- R9: After `eoc` it reads address 0x05 (low byte), then address 0x06 (high byte), and `result` becomes {high, low}.
- R10: A successful run ends by writing 0x00 to address 0x00, and the `done` pulse follows that write's acknowledge.
- R11: Every failure ends with a write of 0x00 to address 0x00 before the `error` pulse. The failures are a bus error on any access, a busy timeout and a conversion timeout.
- R12: `busy` rises in the cycle after an accepted `start` and stays high until the cycle in which `done` or `error` pulses. Each of those pulses lasts exactly one cycle, and the two never coincide.
- R13: The sequencer holds each bus request, with its address and data stable, until `bus_ack` or `bus_err` answers it. It never asserts `bus_re` and `bus_we` together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request a conversion (taken when idle) |
| chan | input | CH_W | Channel number for the request |
| tick | input | 1 | Time-base pulse for poll spacing and timeout |
| eoc | input | 1 | End-of-conversion pulse from the converter |
| bus_addr | output | 8 | Register address |
| bus_wdata | output | 8 | Write data |
| bus_we | output | 1 | Write request |
| bus_re | output | 1 | Read request |
| bus_rdata | input | 8 | Read data, valid with `bus_ack` |
| bus_ack | input | 1 | Access completed |
| bus_err | input | 1 | Access failed |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle success pulse |
| error | output | 1 | One-cycle failure pulse |
| result | output | 16 | Raw conversion result {high, low} |

## Verification
Some properties are checked on every cycle by assertions. These cover bus request exclusivity and request holding, and the single-cycle, mutually exclusive end pulses. They also check that each end pulse follows a zero write to the control register, that the high-byte read directly follows an acknowledged low-byte read, the cap on the poll budget and the timer bound. Other behaviours can only be shown by the bench's scenarios. Those are the exact access order with read-modify-write values that keep unrelated bits, and the current-sense bit for the two special channels. They also include the poll spacing and the conversion-timeout window in cycles, the 9-busy versus 10-busy boundary, a bus error injected mid-sequence, and a start ignored while busy.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_POLL_RD,
        S_POLL_GAP,
        S_EN_RD,
        S_EN_WR,
        S_CH_WR,
        S_BUF_RD,
        S_BUF_WR,
        S_GO_RD,
        S_GO_WR,
        S_EOC_WAIT,
        S_LO_RD,
        S_HI_RD,
        S_OFF_WR,
        S_ABORT_WR
    } seq_state_e;

    // Register addresses decoded by the converter
    localparam logic [7:0] REG_CTL1 = 8'h00;
    localparam logic [7:0] REG_CTL2 = 8'h01;
    localparam logic [7:0] REG_STAT = 8'h04;
    localparam logic [7:0] REG_DLO  = 8'h05;
    localparam logic [7:0] REG_DHI  = 8'h06;

    // Control bit masks
    localparam logic [7:0] CTL1_PWR    = 8'h01;
    localparam logic [7:0] CTL1_GO     = 8'h04;
    localparam logic [7:0] CTL1_BUF    = 8'h40;
    localparam logic [7:0] CTL1_ISENSE = 8'h80;
    localparam logic [7:0] CTL2_AVG16  = 8'h60;
    localparam logic [7:0] STAT_BUSY   = 8'h01;

    function automatic logic is_read_state(seq_state_e s);
        return (s == S_POLL_RD) || (s == S_EN_RD) || (s == S_BUF_RD) ||
               (s == S_GO_RD) || (s == S_LO_RD) || (s == S_HI_RD);
    endfunction

    function automatic logic is_write_state(seq_state_e s);
        return (s == S_EN_WR) || (s == S_CH_WR) || (s == S_BUF_WR) ||
               (s == S_GO_WR) || (s == S_OFF_WR) || (s == S_ABORT_WR);
    endfunction

endpackage

// File: rtl/adcseq_tick_timer.sv
module adcseq_tick_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!run) begin
            cnt_d = '0;
        end else if (tick && (cnt_q != limit)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = run && (cnt_q == limit);

    AST_TMR_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q <= limit)); // R8

endmodule

// File: rtl/adcseq_poll_budget.sv
module adcseq_poll_budget #(
    parameter int POLL_MAX = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic bump,
    output logic last
);
    localparam int BUD_W = $clog2(POLL_MAX + 1);
    localparam logic [BUD_W-1:0] LAST_IDX = BUD_W'(POLL_MAX - 1);

    logic [BUD_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear)     cnt_d = '0;
        else if (bump) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last = (cnt_q == LAST_IDX);

    AST_BUDGET_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST_IDX); // R3

    AST_NO_BUMP_AT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (last && !clear) |-> !bump); // R3

endmodule

// File: rtl/adcseq_bus_drive.sv
module adcseq_bus_drive
    import adcseq_pkg::*;
#(
    parameter int CH_W = 5
) (
    input  seq_state_e      state,
    input  logic [CH_W-1:0] chan,
    input  logic [7:0]      shadow,
    input  logic            isense,
    output logic            re,
    output logic            we,
    output logic [7:0]      addr,
    output logic [7:0]      wdata
);
    always_comb begin
        re    = is_read_state(state);
        we    = is_write_state(state);
        addr  = REG_CTL1;
        wdata = 8'h00;
        unique case (state)
            S_POLL_RD:  addr = REG_STAT;
            S_EN_RD,
            S_BUF_RD,
            S_GO_RD:    addr = REG_CTL1;
            S_EN_WR:    wdata = shadow | CTL1_PWR;
            S_CH_WR: begin
                addr  = REG_CTL2;
                wdata = 8'(chan) | CTL2_AVG16;
            end
            S_BUF_WR:   wdata = shadow | CTL1_BUF | (isense ? CTL1_ISENSE : 8'h00);
            S_GO_WR:    wdata = shadow | CTL1_GO;
            S_LO_RD:    addr = REG_DLO;
            S_HI_RD:    addr = REG_DHI;
            S_OFF_WR,
            S_ABORT_WR: wdata = 8'h00;
            default: begin
                addr  = REG_CTL1;
                wdata = 8'h00;
            end
        endcase
    end
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
    import adcseq_pkg::*;
#(
    parameter int CH_W        = 5,
    parameter int POLL_MAX    = 10,
    parameter int POLL_GAP    = 10,
    parameter int EOC_TIMEOUT = 2000,
    parameter int ISENSE_CH_A = 9,
    parameter int ISENSE_CH_B = 14
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [CH_W-1:0] chan,
    input  logic            tick,
    input  logic            eoc,
    output logic [7:0]      bus_addr,
    output logic [7:0]      bus_wdata,
    output logic            bus_we,
    output logic            bus_re,
    input  logic [7:0]      bus_rdata,
    input  logic            bus_ack,
    input  logic            bus_err,
    output logic            busy,
    output logic            done,
    output logic            error,
    output logic [15:0]     result
);
    localparam int TMR_MAX = (POLL_GAP > EOC_TIMEOUT) ? POLL_GAP : EOC_TIMEOUT;
    localparam int TMR_W   = $clog2(TMR_MAX + 1);
    localparam logic [TMR_W-1:0] GAP_LIM = TMR_W'(POLL_GAP);
    localparam logic [TMR_W-1:0] TMO_LIM = TMR_W'(EOC_TIMEOUT);
    localparam logic [CH_W-1:0]  ISA     = CH_W'(ISENSE_CH_A);
    localparam logic [CH_W-1:0]  ISB     = CH_W'(ISENSE_CH_B);

    typedef struct packed {
        seq_state_e      state;
        logic [CH_W-1:0] chan;
        logic [7:0]      shadow;
        logic [7:0]      lo;
        logic [15:0]     result;
        logic            done;
        logic            error;
    } seq_regs_t;

    seq_regs_t d, q;

    logic             tmr_run;
    logic [TMR_W-1:0] tmr_limit;
    logic             tmr_expired;
    logic             bud_clear;
    logic             bud_bump;
    logic             bud_last;
    logic             isense;
    logic             xfer_ok;
    logic             xfer_bad;

    assign isense   = (q.chan == ISA) || (q.chan == ISB);
    assign xfer_bad = (bus_re || bus_we) && bus_err;
    assign xfer_ok  = (bus_re || bus_we) && bus_ack && !bus_err;

    assign tmr_run   = (q.state == S_POLL_GAP) || (q.state == S_EOC_WAIT);
    assign tmr_limit = (q.state == S_POLL_GAP) ? GAP_LIM : TMO_LIM;

    adcseq_tick_timer #(
        .CNT_W (TMR_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (tmr_run),
        .tick    (tick),
        .limit   (tmr_limit),
        .expired (tmr_expired)
    );

    adcseq_poll_budget #(
        .POLL_MAX (POLL_MAX)
    ) u_budget (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (bud_clear),
        .bump  (bud_bump),
        .last  (bud_last)
    );

    adcseq_bus_drive #(
        .CH_W (CH_W)
    ) u_bus (
        .state  (q.state),
        .chan   (q.chan),
        .shadow (q.shadow),
        .isense (isense),
        .re     (bus_re),
        .we     (bus_we),
        .addr   (bus_addr),
        .wdata  (bus_wdata)
    );

    // Next-state computation
    always_comb begin
        d         = q;
        d.done    = 1'b0;
        d.error   = 1'b0;
        bud_clear = 1'b0;
        bud_bump  = 1'b0;

        unique case (q.state)
            S_IDLE: begin
                bud_clear = 1'b1;
                if (start) begin
                    d.state = S_POLL_RD;
                    d.chan  = chan;
                end
            end

            S_POLL_RD: begin
                if (xfer_bad) begin
                    d.state = S_ABORT_WR;
                end else if (xfer_ok) begin
                    if ((bus_rdata & STAT_BUSY) == 8'h00) begin
                        d.state = S_EN_RD;
                    end else if (bud_last) begin
                        d.state = S_ABORT_WR;
                    end else begin
                        bud_bump = 1'b1;
                        d.state  = S_POLL_GAP;
                    end
                end
            end

            S_POLL_GAP: begin
                if (tmr_expired) d.state = S_POLL_RD;
            end

            S_EN_RD, S_BUF_RD, S_GO_RD: begin
                if (xfer_bad) begin
                    d.state = S_ABORT_WR;
                end else if (xfer_ok) begin
                    d.shadow = bus_rdata;
                    unique case (q.state)
                        S_EN_RD:  d.state = S_EN_WR;
                        S_BUF_RD: d.state = S_BUF_WR;
                        default:  d.state = S_GO_WR;
                    endcase
                end
            end

            S_EN_WR: begin
                if (xfer_bad)     d.state = S_ABORT_WR;
                else if (xfer_ok) d.state = S_CH_WR;
            end

            S_CH_WR: begin
                if (xfer_bad)     d.state = S_ABORT_WR;
                else if (xfer_ok) d.state = S_BUF_RD;
            end

            S_BUF_WR: begin
                if (xfer_bad)     d.state = S_ABORT_WR;
                else if (xfer_ok) d.state = S_GO_RD;
            end

            S_GO_WR: begin
                if (xfer_bad)     d.state = S_ABORT_WR;
                else if (xfer_ok) d.state = S_EOC_WAIT;
            end

            S_EOC_WAIT: begin
                if (eoc)              d.state = S_LO_RD;
                else if (tmr_expired) d.state = S_ABORT_WR;
            end

            S_LO_RD: begin
                if (xfer_bad) begin
                    d.state = S_ABORT_WR;
                end else if (xfer_ok) begin
                    d.lo    = bus_rdata;
                    d.state = S_HI_RD;
                end
            end

            S_HI_RD: begin
                if (xfer_bad) begin
                    d.state = S_ABORT_WR;
                end else if (xfer_ok) begin
                    d.result = {bus_rdata, q.lo};
                    d.state  = S_OFF_WR;
                end
            end

            S_OFF_WR: begin
                if (xfer_bad) begin
                    d.state = S_ABORT_WR;
                end else if (xfer_ok) begin
                    d.state = S_IDLE;
                    d.done  = 1'b1;
                end
            end

            S_ABORT_WR: begin
                if (xfer_bad || xfer_ok) begin
                    d.state = S_IDLE;
                    d.error = 1'b1;
                end
            end

            default: d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state  <= S_IDLE;
            q.chan   <= '0;
            q.shadow <= '0;
            q.lo     <= '0;
            q.result <= '0;
            q.done   <= 1'b0;
            q.error  <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign busy   = (q.state != S_IDLE);
    assign done   = q.done;
    assign error  = q.error;
    assign result = q.result;

    AST_RW_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_re && bus_we)); // R13

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_re || bus_we) && !bus_ack && !bus_err) |=>
        ((bus_re || bus_we) && $stable(bus_addr) && $stable(bus_wdata))); // R13

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R12

    AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        error |=> !error); // R12

    AST_END_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && error)); // R12

    AST_ERR_AFTER_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(error) |-> $past(bus_we && (bus_addr == REG_CTL1) && (bus_wdata == 8'h00))); // R11

    AST_DONE_AFTER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(bus_we && (bus_addr == REG_CTL1) && (bus_wdata == 8'h00) && bus_ack)); // R10

    AST_HI_AFTER_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && (bus_addr == REG_DHI) && !$past(bus_re && (bus_addr == REG_DHI))) |->
        $past(bus_re && (bus_addr == REG_DLO) && bus_ack)); // R9

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(q.chan)); // R2

endmodule

// File: tb/adc_conv_seq_bench.sv
module adc_conv_seq_bench;
    localparam int CH_W = 5;
    localparam int PMAX = 10;
    localparam int GAP  = 3;
    localparam int TMO  = 20;
    localparam int TDIV = 4;
    localparam int ISA  = 9;
    localparam int ISB  = 14;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic            start = 1'b0;
    logic [CH_W-1:0] chan = '0;
    logic            tick;
    logic            eoc;
    logic [7:0]      bus_addr, bus_wdata, bus_rdata;
    logic            bus_we, bus_re, bus_ack, bus_err;
    logic            busy, done, error;
    logic [15:0]     result;

    adc_conv_seq #(
        .CH_W(CH_W), .POLL_MAX(PMAX), .POLL_GAP(GAP), .EOC_TIMEOUT(TMO),
        .ISENSE_CH_A(ISA), .ISENSE_CH_B(ISB)
    ) u_adc_conv_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .chan(chan), .tick(tick), .eoc(eoc),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re),
        .bus_rdata(bus_rdata), .bus_ack(bus_ack), .bus_err(bus_err),
        .busy(busy), .done(done), .error(error), .result(result)
    );

    int tests = 0;
    int fails = 0;
    int cyc = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // time base
    int tdiv_cnt = 0;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        tdiv_cnt <= (tdiv_cnt == TDIV - 1) ? 0 : tdiv_cnt + 1;
        tick <= (tdiv_cnt == TDIV - 1);
    end

    // converter register model
    logic [7:0] ctl1, ctl2, lo_v, hi_v;
    int busy_left = 0, err_idx = -1, tidx = 0, eoc_delay = -1, eoc_cnt = 0;
    logic [16:0] obs_q[$];
    int          obs_cyc[$];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_ack <= 1'b0; bus_err <= 1'b0; bus_rdata <= 8'h00;
            eoc <= 1'b0; eoc_cnt <= 0;
        end else begin
            bus_ack <= 1'b0; bus_err <= 1'b0; eoc <= 1'b0;
            if (eoc_cnt > 0) begin
                eoc_cnt <= eoc_cnt - 1;
                if (eoc_cnt == 1) eoc <= 1'b1;
            end
            if ((bus_re || bus_we) && !bus_ack && !bus_err) begin
                obs_q.push_back({bus_we, bus_addr, bus_we ? bus_wdata : 8'h00});
                obs_cyc.push_back(cyc);
                if (tidx == err_idx) begin
                    bus_err <= 1'b1;
                end else begin
                    bus_ack <= 1'b1;
                    if (bus_we) begin
                        if (bus_addr == 8'h00) begin
                            ctl1 <= bus_wdata;
                            if (bus_wdata[2] && eoc_delay >= 1) eoc_cnt <= eoc_delay + 1;
                        end
                        if (bus_addr == 8'h01) ctl2 <= bus_wdata;
                    end else begin
                        case (bus_addr)
                            8'h00: bus_rdata <= ctl1;
                            8'h04: begin
                                bus_rdata <= (busy_left > 0) ? 8'h81 : 8'h80;
                                if (busy_left > 0) busy_left <= busy_left - 1;
                            end
                            8'h05: bus_rdata <= lo_v;
                            8'h06: bus_rdata <= hi_v;
                            default: bus_rdata <= 8'hEE;
                        endcase
                    end
                end
                tidx <= tidx + 1;
            end
        end
    end

    // cycle-by-cycle busy / pulse model
    bit mon_on = 0;
    bit acc_prev = 0, busy_prev = 0, done_prev = 0, err_prev = 0;
    int done_cnt = 0, err_cnt = 0;
    logic [15:0] res_cap = '0;
    always @(negedge clk) begin
        if (mon_on) begin
            chk(busy == (acc_prev || (busy_prev && !(done || error))), "R12", "busy vs model",
                busy, acc_prev || (busy_prev && !(done || error)));
            chk(!(done && error), "R12", "done and error together", {done, error}, 0);
            chk(!(done && done_prev) && !(error && err_prev), "R12", "pulse longer than one cycle",
                {done, error}, 0);
            chk(!(bus_re && bus_we), "R13", "re and we together", {bus_re, bus_we}, 0);
            if (done) begin done_cnt++; res_cap = result; end
            if (error) err_cnt++;
        end
        acc_prev = start && !busy;
        busy_prev = busy; done_prev = done; err_prev = error;
    end

    logic [16:0] exp_q[$];

    function automatic logic [16:0] rd(input logic [7:0] a);
        return {1'b0, a, 8'h00};
    endfunction
    function automatic logic [16:0] wr(input logic [7:0] a, input logic [7:0] v);
        return {1'b1, a, v};
    endfunction

    task automatic run_case(input string req, input int ch, input int nbusy, input int edly,
                            input int eidx, input logic [7:0] c0, input logic [7:0] lo,
                            input logic [7:0] hi, input int ign_ch);
        logic [7:0] c;
        bit ok_exp;
        int d0, e0, wait_n;
        bit isen;
        exp_q.delete();
        isen = (ch == ISA) || (ch == ISB);
        for (int i = 0; i < ((nbusy < PMAX) ? nbusy + 1 : PMAX); i++) exp_q.push_back(rd(8'h04));
        if (nbusy < PMAX) begin
            c = c0;
            exp_q.push_back(rd(8'h00)); c = c | 8'h01; exp_q.push_back(wr(8'h00, c));
            exp_q.push_back(wr(8'h01, 8'(ch) | 8'h60));
            exp_q.push_back(rd(8'h00)); c = c | 8'h40 | (isen ? 8'h80 : 8'h00);
            exp_q.push_back(wr(8'h00, c));
            exp_q.push_back(rd(8'h00)); c = c | 8'h04; exp_q.push_back(wr(8'h00, c));
            if (edly >= 1) begin
                exp_q.push_back(rd(8'h05)); exp_q.push_back(rd(8'h06));
            end
        end
        if (eidx >= 0) begin
            while (exp_q.size() > eidx + 1) void'(exp_q.pop_back());
        end
        exp_q.push_back(wr(8'h00, 8'h00));
        ok_exp = (nbusy < PMAX) && (edly >= 1) && (eidx < 0);

        ctl1 = c0; ctl2 = 8'h00; lo_v = lo; hi_v = hi;
        busy_left = nbusy; err_idx = eidx; eoc_delay = edly; tidx = 0;
        obs_q.delete(); obs_cyc.delete();
        d0 = done_cnt; e0 = err_cnt;

        @(posedge clk); #1 start = 1'b1; chan = CH_W'(ch);
        @(posedge clk); #1 start = 1'b0; chan = '0;
        if (ign_ch >= 0) begin
            repeat (6) @(posedge clk);
            #1 start = 1'b1; chan = CH_W'(ign_ch);
            @(posedge clk); #1 start = 1'b0; chan = '0;
        end
        wait_n = 0;
        while (done_cnt == d0 && err_cnt == e0 && wait_n < 3000) begin
            @(posedge clk); wait_n++;
        end
        repeat (4) @(posedge clk);
        @(negedge clk);

        chk(done_cnt - d0 == (ok_exp ? 1 : 0), ok_exp ? "R10" : "R11", {req, " done pulses"},
            done_cnt - d0, ok_exp ? 1 : 0);
        chk(err_cnt - e0 == (ok_exp ? 0 : 1), ok_exp ? "R10" : "R11", {req, " error pulses"},
            err_cnt - e0, ok_exp ? 0 : 1);
        chk(obs_q.size() == exp_q.size(), req, "access count", obs_q.size(), exp_q.size());
        for (int i = 0; i < exp_q.size() && i < obs_q.size(); i++)
            chk(obs_q[i] == exp_q[i], req, $sformatf("access %0d {we,addr,data}", i), obs_q[i], exp_q[i]);
        if (ok_exp) chk(res_cap == {hi, lo}, "R9", {req, " result"}, res_cap, {hi, lo});
        chk(busy == 1'b0, "R12", {req, " idle after run"}, busy, 0);

        // poll spacing
        if (nbusy > 0) begin
            for (int i = 1; i < ((nbusy < PMAX) ? nbusy + 1 : PMAX) && i < obs_cyc.size(); i++) begin
                int gap_c = obs_cyc[i] - obs_cyc[i-1];
                chk(gap_c >= (GAP - 1) * TDIV + 4 && gap_c <= GAP * TDIV + 3, "R3",
                    $sformatf("%s poll spacing %0d", req, i), gap_c, GAP * TDIV);
            end
        end
        // timeout window: start write to shutdown write
        if (edly < 1 && nbusy < PMAX && eidx < 0 && obs_cyc.size() >= 2) begin
            int tw = obs_cyc[obs_cyc.size()-1] - obs_cyc[obs_cyc.size()-2];
            chk(tw >= (TMO - 1) * TDIV + 4 && tw <= TMO * TDIV + 3, "R8", "timeout window", tw, TMO * TDIV);
        end
    endtask

    initial begin : watchdog
        #(8 * 200000);
        fails++; tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        ctl1 = 8'h00; ctl2 = 8'h00; lo_v = 8'h00; hi_v = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(busy == 0 && done == 0 && error == 0, "R1", "status in reset", {busy, done, error}, 0);
        chk(bus_re == 0 && bus_we == 0, "R1", "bus idle in reset", {bus_re, bus_we}, 0);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 0 && done == 0 && error == 0 && bus_re == 0 && bus_we == 0, "R1",
            "state after reset", {busy, done, error, bus_re, bus_we}, 0);
        mon_on = 1;

        // plain run, RMW keeps bit 4 (R4 R5 R6 R7 R9 R10)
        run_case("R4", 3, 0, 5, -1, 8'h10, 8'hAB, 8'h02, -1);
        // current-sense channel A after two busy polls (R6 R3)
        run_case("R6", ISA, 2, 3, -1, 8'h00, 8'hFF, 8'h03, -1);
        // current-sense channel B (R6)
        run_case("R6", ISB, 0, 2, -1, 8'h20, 8'h34, 8'h01, -1);
        // nine busy polls then clean: still succeeds (R3 boundary)
        run_case("R3", 7, PMAX - 1, 4, -1, 8'h00, 8'h55, 8'h00, -1);
        // ten busy polls: error with shutdown (R3 R11)
        run_case("R3", 7, PMAX, 4, -1, 8'h00, 8'h00, 8'h00, -1);
        // no end-of-conversion: timeout (R8 R11)
        run_case("R8", 1, 0, -1, -1, 8'h00, 8'h00, 8'h00, -1);
        // bus error on channel write (R11)
        run_case("R11", 2, 0, 3, 3, 8'h00, 8'h00, 8'h00, -1);
        // bus error on low-byte read (R11)
        run_case("R11", 4, 1, 3, 9, 8'h00, 8'h00, 8'h00, -1);
        // start while busy is ignored (R2)
        run_case("R2", 5, 0, 6, -1, 8'h00, 8'h11, 8'h22, 12);
        // channel write carries averaging bits (R5) and protocol (R13)
        run_case("R5", 31, 0, 2, -1, 8'h08, 8'h9A, 8'h03, -1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule